// File: doc/BRIEF.md
# Counter-Indexed Scratch Memory

This block holds four independent data banks of 64 words of 32 bits each, 1 KB in all. No bank has an address input. Each bank is indexed by a private 6-bit index counter, so the only way to pick a word is to move that counter. The sequencer's datapath can read any set of the four banks and write one bank in the same cycle. On each access it chooses whether the bank's counter stays put or steps forward by one after the access. An instruction can also load a counter. The new index is seen by the next instruction, while the current one still uses the old index.

While the sequencer is halted, a host port takes over the banks through the same counters. A host word read or word write always steps the counter of the selected bank. A host counter-load command places an index directly. All four counters are visible to the host at all times. A power-on reset clears the counters. A soft reset only clears the registered read outputs and leaves the counters and the stored words as they were.

Top module: `banked_scratch_ram`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge), every counter is 0, and every `rd_data` lane and `host_rdata` are 0.
- R2: With `halted` low and `wr_en` high, `wr_data` is stored at the current index of bank `wr_bank`. That bank's counter then advances by one if `wr_inc` is high and is otherwise unchanged.
- R3: With `halted` low, each bank b with `rd_en[b]` high places the word at its current index on lane b of `rd_data` (bits 32b+31..32b) one clock edge later. It post-increments its counter when `rd_inc[b]` is high. All four lanes work independently in the same cycle, and a lane holds its value while its bank is not read.
- R4: A load (`ld_en`, `ld_bank`, `ld_value`) sets the counter at the edge. Accesses issued in the same cycle use the old index and the next cycle uses the new one. A load overrides any increment of that bank in the same cycle.
- R5: When one bank is read with increment and written with increment in the same cycle, its counter advances by exactly one, and the read returns the word held before the write.
- R6: Counters are 6 bits wide and wrap from 63 to 0 on increment.
- R7: With `halted` high, the host port acts on bank `host_bank`. The host commands have this priority: `host_ld` loads the counter from `host_wdata[5:0]` without increment. Otherwise `host_wr` stores `host_wdata` at the index and increments. Otherwise `host_rd` puts the word at the index on `host_rdata` one edge later and increments.
- R8: While `halted` is high, the datapath inputs (`rd_en`, `wr_en`, `ld_en`) have no effect. While `halted` is low, the host commands have no effect.
- R9: A soft reset (`soft_rst_n` low at an edge) clears all `rd_data` lanes and `host_rdata` but leaves the counters and the memory contents unchanged.
- R10: `ct_out` bits 6b+5..6b carry bank b's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low; clears read outputs only |
| halted | input | 1 | Sequencer halted: host port enabled, datapath disabled |
| rd_en | input | 4 | Per-bank datapath read request |
| rd_inc | input | 4 | Per-bank post-increment on read |
| rd_data | output | 128 | Registered read lanes, bank b at bits 32b+31..32b |
| wr_en | input | 1 | Datapath write request |
| wr_bank | input | 2 | Bank written by the datapath |
| wr_inc | input | 1 | Post-increment on datapath write |
| wr_data | input | 32 | Datapath write word |
| ld_en | input | 1 | Datapath counter load |
| ld_bank | input | 2 | Bank whose counter is loaded |
| ld_value | input | 6 | New index |
| host_bank | input | 2 | Bank selected by the host |
| host_ld | input | 1 | Host counter load from host_wdata[5:0] |
| host_wr | input | 1 | Host word write |
| host_rd | input | 1 | Host word read |
| host_wdata | input | 32 | Host write word or load index |
| host_rdata | output | 32 | Registered host read word |
| ct_out | output | 24 | All counters, bank b at bits 6b+5..6b |

## Verification
The bench fills every word of every bank through the host and reads all 256 back. It then sweeps all four datapath lanes together, which would expose a lane wired to the wrong bank or a counter that fails to step or wrap at 63. It aims at same-cycle collisions: a load racing an increment, and a read and a write with increment on one bank. A design that applied a load at once, counted twice, or forwarded the new word would show a wrong index or a wrong word. It also drives host commands while running, datapath commands while halted, and a soft reset, where a leaky gate or a reset that touched the counters would change `ct_out`.

// File: rtl/scratch_pkg.sv
// Package: shared constants and the host command decode for the scratch memory.
// Assumes the host command strobes may be raised together; priority is resolved here.
package scratch_pkg;

    localparam int unsigned SCR_BANKS = 4;
    localparam int unsigned SCR_DEPTH = 64;
    localparam int unsigned SCR_WIDTH = 32;

    typedef enum logic [1:0] {
        HOP_IDLE  = 2'd0,
        HOP_LOAD  = 2'd1,
        HOP_WRITE = 2'd2,
        HOP_READ  = 2'd3
    } host_op_e;

    // Resolve concurrent host strobes: load beats write beats read.
    function automatic host_op_e host_decode(input logic ld, input logic wr, input logic rd);
        if (ld)      return HOP_LOAD;
        else if (wr) return HOP_WRITE;
        else if (rd) return HOP_READ;
        else         return HOP_IDLE;
    endfunction

endpackage

// File: rtl/scratch_counter.sv
// Module: index counter of one bank.
// A load takes effect at the clock edge, so the issuing cycle still sees the
// old index; a load beats an increment. Increments wrap at 2**CT_W.
// Assumes all increment sources of the bank are already merged into one bit.
module scratch_counter #(
    parameter int unsigned CT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [CT_W-1:0] ld_val,
    input  logic            inc,
    output logic [CT_W-1:0] cnt
);

    // Counter register: power-on clear, load, then single-step increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));

    assert_step_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> cnt == $past(cnt) + 1'b1);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld) |=> $stable(cnt));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && cnt == {CT_W{1'b1}}) |=> cnt == '0);

endmodule

// File: rtl/scratch_bank.sv
// Module: one storage bank with a single address (the bank counter), one write
// and one registered read per cycle. A read in the cycle of a write to the same
// word returns the old word. The read register clears on either reset; the
// storage itself is never reset.
module scratch_bank #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Storage write at the counter index.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Registered read, cleared by power-on or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) q <= '0;
        else if (re)               q <= mem[addr];
    end

    assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> q == '0);

    assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !soft_rst_n)
        !re |=> $stable(q));

endmodule

// File: rtl/banked_scratch_ram.sv
// Module: four counter-indexed scratch banks shared by a sequencer datapath and
// a host port. The datapath owns the banks while the sequencer runs; the host
// owns them while it is halted. Each bank is addressed only by its counter.
// Assumes DEPTH is a power of two so that the counter wrap matches the bank.
module banked_scratch_ram
    import scratch_pkg::*;
#(
    parameter int unsigned NB    = SCR_BANKS,
    parameter int unsigned DEPTH = SCR_DEPTH,
    parameter int unsigned WIDTH = SCR_WIDTH,
    localparam int unsigned CT_W = $clog2(DEPTH),
    localparam int unsigned BW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst_n,
    input  logic               halted,
    input  logic [NB-1:0]      rd_en,
    input  logic [NB-1:0]      rd_inc,
    output logic [NB*WIDTH-1:0] rd_data,
    input  logic               wr_en,
    input  logic [BW-1:0]      wr_bank,
    input  logic               wr_inc,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic               ld_en,
    input  logic [BW-1:0]      ld_bank,
    input  logic [CT_W-1:0]    ld_value,
    input  logic [BW-1:0]      host_bank,
    input  logic               host_ld,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [WIDTH-1:0]   host_wdata,
    output logic [WIDTH-1:0]   host_rdata,
    output logic [NB*CT_W-1:0] ct_out
);

    host_op_e         hop;
    logic [WIDTH-1:0] lane_q [NB];
    logic [BW-1:0]    host_sel_q;
    logic             host_read_any;

    // Host command after priority resolution.
    always_comb hop = host_decode(host_ld, host_wr, host_rd);

    // A host read happens only when halted and no higher command is present.
    always_comb host_read_any = halted && (hop == HOP_READ);

    // Remember which bank the last host read used, for the host read mux.
    always_ff @(posedge clk) begin
        if (!rst_n)             host_sel_q <= '0;
        else if (host_read_any) host_sel_q <= host_bank;
    end

    // Host read data: the lane of the bank last read by the host.
    always_comb host_rdata = lane_q[host_sel_q];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic             h_sel, h_ld, h_wr, h_rd;
        logic             d_ld, d_wr, d_rd;
        logic             c_ld, c_inc, b_we, b_re;
        logic [CT_W-1:0]  c_val, ct;
        logic [WIDTH-1:0] b_wdata;

        // Per-bank ownership gating of host and datapath requests.
        always_comb begin
            h_sel = halted && (host_bank == BW'(b));
            h_ld  = h_sel && (hop == HOP_LOAD);
            h_wr  = h_sel && (hop == HOP_WRITE);
            h_rd  = h_sel && (hop == HOP_READ);
            d_ld  = !halted && ld_en && (ld_bank == BW'(b));
            d_wr  = !halted && wr_en && (wr_bank == BW'(b));
            d_rd  = !halted && rd_en[b];
        end

        // Merge the request sources into one load, one increment, one write, one read.
        always_comb begin
            c_ld    = h_ld || d_ld;
            c_val   = h_ld ? host_wdata[CT_W-1:0] : ld_value;
            c_inc   = h_wr || h_rd || (d_wr && wr_inc) || (d_rd && rd_inc[b]);
            b_we    = h_wr || d_wr;
            b_wdata = h_wr ? host_wdata : wr_data;
            b_re    = h_rd || d_rd;
        end

        scratch_counter #(.CT_W(CT_W)) i_ct (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (c_ld),
            .ld_val (c_val),
            .inc    (c_inc),
            .cnt    (ct)
        );

        scratch_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst_n (soft_rst_n),
            .addr       (ct),
            .we         (b_we),
            .wdata      (b_wdata),
            .re         (b_re),
            .q          (lane_q[b])
        );

        // Output packing of the lane and the counter of this bank.
        always_comb begin
            rd_data[b*WIDTH +: WIDTH] = lane_q[b];
            ct_out[b*CT_W +: CT_W]    = ct;
        end

        assert_host_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!halted && !(ld_en && ld_bank == BW'(b)) && !(wr_en && wr_bank == BW'(b)) && !rd_en[b])
            |=> $stable(ct_out[b*CT_W +: CT_W]));

        assert_dp_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (halted && host_bank != BW'(b)) |=> $stable(ct_out[b*CT_W +: CT_W]));

        assert_host_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (halted && host_ld && host_bank == BW'(b))
            |=> ct_out[b*CT_W +: CT_W] == $past(host_wdata[CT_W-1:0]));
    end

endmodule

// File: tb/test_banked_scratch_ram.sv
`timescale 1ns/100ps
// Bench: fills and sweeps every word through both ports, then hits the
// same-cycle collisions, port ownership and soft reset. The expected state is
// kept in a bench model that follows the requirement text.
module test_banked_scratch_ram;

    logic         clk = 1'b0;
    logic         rst_n, soft_rst_n, halted;
    logic [3:0]   rd_en, rd_inc;
    logic [127:0] rd_data;
    logic         wr_en, wr_inc;
    logic [1:0]   wr_bank, ld_bank, host_bank;
    logic [31:0]  wr_data, host_wdata, host_rdata;
    logic         ld_en, host_ld, host_wr, host_rd;
    logic [5:0]   ld_value;
    logic [23:0]  ct_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] mem_m  [4][64];
    logic [31:0] lane_m [4];
    int          ct_m   [4];
    int          hsel_m;

    always #2.5 clk = ~clk;

    banked_scratch_ram i_banked_scratch_ram (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .halted(halted),
        .rd_en(rd_en), .rd_inc(rd_inc), .rd_data(rd_data),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_inc(wr_inc), .wr_data(wr_data),
        .ld_en(ld_en), .ld_bank(ld_bank), .ld_value(ld_value),
        .host_bank(host_bank), .host_ld(host_ld), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ct_out(ct_out)
    );

    function automatic logic [31:0] pat(int b, int i, int salt);
        return 32'hA500_0000 ^ (32'(b) << 20) ^ (32'(i) * 32'h0001_0101) ^ (32'(salt) << 28);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every lane, the host port and every counter with the model.
    task automatic check_all(string tag);
        for (int b = 0; b < 4; b++) begin
            check($sformatf("%s lane%0d", tag, b), rd_data[b*32 +: 32], lane_m[b]);
            check($sformatf("%s/R10 ct%0d", tag, b), 32'(ct_out[b*6 +: 6]), 32'(ct_m[b]));
        end
        check($sformatf("%s host_rdata", tag), host_rdata, lane_m[hsel_m]);
    endtask

    task automatic idle();
        rd_en = '0; rd_inc = '0; wr_en = 0; wr_bank = '0; wr_inc = 0; wr_data = '0;
        ld_en = 0; ld_bank = '0; ld_value = '0;
        host_bank = '0; host_ld = 0; host_wr = 0; host_rd = 0; host_wdata = '0;
    endtask

    // One clock: predict from the requirements, take the edge, commit the model.
    task automatic step();
        logic [31:0] ln [4];
        bit inc [4];
        bit ldb [4];
        int lv  [4];
        int hs;
        hs = hsel_m;
        for (int b = 0; b < 4; b++) begin
            ln[b] = lane_m[b]; inc[b] = 0; ldb[b] = 0; lv[b] = 0;
        end
        if (!halted) begin
            for (int b = 0; b < 4; b++)
                if (rd_en[b]) begin
                    ln[b] = mem_m[b][ct_m[b]];
                    if (rd_inc[b]) inc[b] = 1;
                end
            if (wr_en) begin
                mem_m[wr_bank][ct_m[wr_bank]] = wr_data;
                if (wr_inc) inc[wr_bank] = 1;
            end
            if (ld_en) begin ldb[ld_bank] = 1; lv[ld_bank] = int'(ld_value); end
        end else begin
            if (host_ld) begin
                ldb[host_bank] = 1; lv[host_bank] = int'(host_wdata[5:0]);
            end else if (host_wr) begin
                mem_m[host_bank][ct_m[host_bank]] = host_wdata; inc[host_bank] = 1;
            end else if (host_rd) begin
                ln[host_bank] = mem_m[host_bank][ct_m[host_bank]];
                inc[host_bank] = 1; hs = int'(host_bank);
            end
        end
        if (!soft_rst_n) for (int b = 0; b < 4; b++) ln[b] = '0;
        @(posedge clk); #1;
        for (int b = 0; b < 4; b++) begin
            lane_m[b] = ln[b];
            ct_m[b] = ldb[b] ? lv[b] : (inc[b] ? (ct_m[b] + 1) % 64 : ct_m[b]);
        end
        hsel_m = hs;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        idle();
        rst_n = 0; soft_rst_n = 1; halted = 1;
        for (int b = 0; b < 4; b++) begin lane_m[b] = '0; ct_m[b] = 0; end
        hsel_m = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check_all("R1 reset");

        // R7 host fill of all words; R6 wrap after 64 writes.
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 64; i++) begin
                idle(); host_bank = 2'(b); host_wr = 1; host_wdata = pat(b, i, 0);
                step();
                check($sformatf("R7 host write ct%0d", b), 32'(ct_out[b*6 +: 6]), 32'(ct_m[b]));
            end
            check($sformatf("R6 wrap ct%0d", b), 32'(ct_out[b*6 +: 6]), 32'd0);
        end
        // R7 host read back of all words.
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 64; i++) begin
                idle(); host_bank = 2'(b); host_rd = 1;
                step();
                check_all("R7 host read");
            end
        // R7 priority: load beats write and read.
        idle(); host_bank = 2'd3; host_ld = 1; host_wr = 1; host_rd = 1; host_wdata = 32'hFFFF_FF2A;
        step(); check_all("R7 priority");
        idle(); host_bank = 2'd3; host_rd = 1;
        step(); check_all("R7 no write on load");

        // R3 running: sweep all four lanes together.
        halted = 0;
        idle(); ld_en = 1; ld_bank = 2'd3; ld_value = 6'd0;
        step(); check_all("R4 load");
        for (int i = 0; i < 64; i++) begin
            idle(); rd_en = 4'hF; rd_inc = 4'hF;
            step(); check_all("R3 sweep");
        end
        for (int i = 0; i < 3; i++) begin
            idle(); rd_en = 4'hF; rd_inc = 4'b0101;
            step(); check_all("R3 mixed inc");
        end

        // R4 load in the same cycle as a read with increment.
        idle(); ld_en = 1; ld_bank = 2'd1; ld_value = 6'd10; rd_en = 4'b0010; rd_inc = 4'b0010;
        step(); check_all("R4 load vs inc");
        idle(); rd_en = 4'b0010;
        step(); check_all("R4 new index");

        // R2 datapath writes across the wrap, then without increment.
        idle(); ld_en = 1; ld_bank = 2'd0; ld_value = 6'd60;
        step();
        for (int i = 0; i < 5; i++) begin
            idle(); wr_en = 1; wr_bank = 2'd0; wr_inc = 1; wr_data = pat(0, i, 5);
            step(); check_all("R2 write inc");
        end
        idle(); wr_en = 1; wr_bank = 2'd0; wr_inc = 0; wr_data = 32'h1234_5678;
        step(); check_all("R2 write hold");
        idle(); ld_en = 1; ld_bank = 2'd0; ld_value = 6'd60;
        step();
        for (int i = 0; i < 6; i++) begin
            idle(); rd_en = 4'b0001; rd_inc = 4'b0001;
            step(); check_all("R2 readback");
        end

        // R5 read and write with increment on one bank in one cycle.
        idle(); ld_en = 1; ld_bank = 2'd2; ld_value = 6'd5;
        step();
        idle(); rd_en = 4'b0100; rd_inc = 4'b0100; wr_en = 1; wr_bank = 2'd2; wr_inc = 1;
        wr_data = 32'hCAFE_0005;
        step(); check_all("R5 collide");
        idle(); ld_en = 1; ld_bank = 2'd2; ld_value = 6'd5;
        step();
        idle(); rd_en = 4'b0100;
        step(); check_all("R5 new word");

        // R8 host ignored while running.
        idle(); host_bank = 2'd0; host_wr = 1; host_ld = 0; host_wdata = 32'hDEAD_0000;
        step(); check_all("R8 host write running");
        idle(); host_bank = 2'd0; host_ld = 1; host_wdata = 32'h0000_0033;
        step(); check_all("R8 host load running");
        idle(); host_bank = 2'd1; host_rd = 1;
        step(); check_all("R8 host read running");
        idle(); rd_en = 4'b0001;
        step(); check_all("R8 memory untouched");
        // R8 datapath ignored while halted.
        halted = 1;
        idle(); wr_en = 1; wr_bank = 2'd1; wr_inc = 1; wr_data = 32'hBAD0_BAD0;
        rd_en = 4'hF; rd_inc = 4'hF; ld_en = 1; ld_bank = 2'd2; ld_value = 6'd40;
        step(); check_all("R8 dp halted");
        idle(); host_bank = 2'd1; host_rd = 1;
        step(); check_all("R8 dp write dropped");

        // R9 soft reset clears outputs only.
        idle(); soft_rst_n = 0;
        step(); check_all("R9 soft reset");
        soft_rst_n = 1;
        for (int b = 0; b < 4; b++) begin
            idle(); host_bank = 2'(b); host_rd = 1;
            step(); check_all("R9 contents kept");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule